// File: doc/BRIEF.md
# Single-Level Vectored Interrupt Controller

This block arbitrates fifteen interrupt channels for a small processor core. Channels are numbered 1 to 15 and each owns one bit of a 16-bit word. Bit 0 exists in every word but can never raise an interrupt. The controller holds an enable mask, a pending word, a holding word for device wakeups that arrive while interrupts are off, and a staging word for requests posted by software. On each instruction-boundary pulse, while interrupts are on, the controller checks whether any channel is both pending and enabled in the mask. If one is, it takes the highest-numbered such channel. It clears that channel's pending bit, turns interrupts off, captures the current PC, and presents two addresses: a fixed PC-save address and the address of the vector-table entry for the winning channel.

Device logic posts wakeups with a bit vector.
- While interrupts are on, a wakeup goes straight into the pending word, so it is seen at the next boundary.
- While interrupts are off, a wakeup collects in the holding word.

Software posts with an OR-write. That request is staged and joins the pending word only on the next enable strobe. The enable strobe also moves the holding word into the pending word. The vector table runs downward: its first entry serves channel 15 and its last entry serves channel 1. The system assigns channel 15 to memory parity errors. To the controller it is an ordinary channel, and it has the highest priority.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, interrupts are off and the mask, pending, holding and staging words are zero. A boundary pulse then produces no take, and neither does an enable followed by a boundary pulse.
- R2: `take_o` pulses for one cycle, in the cycle after a boundary pulse. It pulses only if interrupts were on at that boundary and some channel 1..15 had both its pending bit and its mask bit set.
- R3: When several channels qualify at once, the one with the largest number wins. `chan_o` carries that number as a binary value, and the value holds until the next take.
- R4: Taking an interrupt turns interrupts off. Later boundary pulses take nothing until an enable strobe.
- R5: `pc_save_addr_o` is always octal 500. `saved_pc_o` holds the `pc_i` value sampled at the boundary of the most recent take (zero after reset).
- R6: `vec_addr_o` = octal 501 + (15 − N) for the winning channel N. Channel 15 therefore gives octal 501 and channel 1 gives octal 517.
- R7: A device wakeup posted while interrupts are on can be taken at a boundary pulse one cycle later.
- R8: A device wakeup posted while interrupts are off is held. It joins the pending word on the next enable strobe and is not lost.
- R9: A software OR-write (`sw_post_we_i`) is staged and joins the pending word only on a later enable strobe. A post in the same cycle as an enable waits for the following enable.
- R10: On a take, only the winner's pending bit is cleared, even if the same bit is posted in that cycle. Other pending bits stay set and are taken in later rounds.
- R11: A device wakeup and a software post in the same cycle are both kept.
- R12: Bit 0 never causes a take, whatever is written to the mask, device or software inputs.
- R13: `int_off_i` turns interrupts off. When it is asserted together with `int_on_i`, the off strobe wins and no merge happens.
- R14: A mask write replaces the whole mask. A pending channel whose mask bit is 0 is not taken, and becomes eligible once its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_wake_i | input | 16 | Device wakeup bits |
| sw_post_we_i | input | 1 | Software OR-write strobe |
| sw_post_i | input | 16 | Bits for the software OR-write |
| mask_we_i | input | 1 | Mask write strobe |
| mask_i | input | 16 | New mask value |
| int_on_i | input | 1 | Enable strobe; also merges the held and staged words |
| int_off_i | input | 1 | Disable strobe |
| boundary_i | input | 1 | Instruction-boundary pulse |
| pc_i | input | 16 | Current PC |
| take_o | output | 1 | Interrupt taken (one-cycle pulse) |
| chan_o | output | 4 | Number of the winning channel |
| pc_save_addr_o | output | 16 | Fixed PC-save address |
| vec_addr_o | output | 16 | Vector-table entry address |
| saved_pc_o | output | 16 | PC captured at the take |

## Verification
Directed sequences each isolate one path into the pending word:
- a device wakeup while enabled, against one while disabled;
- a software post, with and without a following enable;
- a device wakeup and a software post landing in the same cycle;
- the off and on strobes asserted together.

Multi-bit wakeups show whether the controller picks the highest channel first and clears only that bit. The table extremes, channel 15 and channel 1, expose an inverted or shifted vector offset. Bit-0-only and masked-channel patterns show whether eligibility ignores the reserved bit and the mask. Long random runs then mix every strobe against a bench model, to catch ordering slips between merge, clear and take.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    IEN_KEEP,
    IEN_SET,
    IEN_CLR
  } ien_act_e;
endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int unsigned W     = 16,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [W-1:0]     onehot_o
);
  logic [W:0] above;
  assign above[W] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign above[i]    = above[i+1] | req_i[i];
    assign onehot_o[i] = req_i[i] & ~above[i+1];
  end

  assign valid_o = above[0];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/vic_wake_acc.sv
module vic_wake_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ien_i,
  input  logic         merge_i,
  input  logic [W-1:0] dev_i,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_i,
  output logic [W-1:0] add_o
);
  logic [W-1:0] hold_q, stage_q;
  logic         dev_direct;

  // device bits bypass the holding word when enabled or being enabled
  assign dev_direct = ien_i | merge_i;
  assign add_o = (dev_direct ? dev_i : '0) | (merge_i ? (hold_q | stage_q) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      stage_q <= '0;
    end else begin
      if (merge_i)      hold_q <= '0;
      else if (!ien_i)  hold_q <= hold_q | dev_i;

      // a post in the merge cycle waits for the next merge
      if (merge_i)      stage_q <= sw_we_i ? sw_i : '0;
      else if (sw_we_i) stage_q <= stage_q | sw_i;
    end
  end

  a_r8_hold_cleared_on_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_i |=> (hold_q == '0));
  a_r9_stage_keeps_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && !merge_i) |=> ((stage_q & $past(sw_i)) == $past(sw_i)));
endmodule

// File: rtl/vic_vec_gen.sv
module vic_vec_gen #(
  parameter int unsigned NCH      = 15,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned AW       = 16,
  parameter int unsigned PC_W     = 16,
  parameter logic [AW-1:0] VEC_BASE = AW'(16'o501)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             take_o,
  output logic [IDX_W-1:0] chan_o,
  output logic [AW-1:0]    vec_o,
  output logic [PC_W-1:0]  pc_o
);
  logic [AW-1:0] vec_d;
  // table runs downward from the highest channel
  assign vec_d = VEC_BASE + AW'(NCH) - AW'(idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o <= 1'b0;
      chan_o <= '0;
      vec_o  <= '0;
      pc_o   <= '0;
    end else begin
      take_o <= take_i;
      if (take_i) begin
        chan_o <= idx_i;
        vec_o  <= vec_d;
        pc_o   <= pc_i;
      end
    end
  end

  a_r12_no_chan_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (chan_o != '0));
  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int unsigned NCH  = 15,
  parameter int unsigned AW   = 16,
  parameter int unsigned PC_W = 16,
  parameter logic [AW-1:0] PC_SAVE_ADDR = AW'(16'o500),
  parameter logic [AW-1:0] VEC_BASE     = AW'(16'o501),
  localparam int unsigned W     = NCH + 1,
  localparam int unsigned IDX_W = $clog2(NCH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     dev_wake_i,
  input  logic             sw_post_we_i,
  input  logic [W-1:0]     sw_post_i,
  input  logic             mask_we_i,
  input  logic [W-1:0]     mask_i,
  input  logic             int_on_i,
  input  logic             int_off_i,
  input  logic             boundary_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             take_o,
  output logic [IDX_W-1:0] chan_o,
  output logic [AW-1:0]    pc_save_addr_o,
  output logic [AW-1:0]    vec_addr_o,
  output logic [PC_W-1:0]  saved_pc_o
);
  import vic_pkg::*;

  logic           ien_q;
  logic [W-1:0]   mask_q, pend_q, add, elig, win_oh;
  logic           win_valid, take_now, merge;
  logic [IDX_W-1:0] win_idx;
  ien_act_e       ien_act;

  assign merge = int_on_i & ~int_off_i;

  vic_wake_acc #(.W(W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ien_i   (ien_q),
    .merge_i (merge),
    .dev_i   (dev_wake_i),
    .sw_we_i (sw_post_we_i),
    .sw_i    (sw_post_i),
    .add_o   (add)
  );

  // bit 0 is reserved and never eligible
  assign elig = pend_q & mask_q & ~W'(1);

  vic_prio_enc #(.W(W), .IDX_W(IDX_W)) u_enc (
    .req_i    (elig),
    .valid_o  (win_valid),
    .idx_o    (win_idx),
    .onehot_o (win_oh)
  );

  assign take_now = boundary_i & ien_q & win_valid;

  always_comb begin
    if (take_now || int_off_i) ien_act = IEN_CLR;
    else if (int_on_i)         ien_act = IEN_SET;
    else                       ien_act = IEN_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= 1'b0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      case (ien_act)
        IEN_SET: ien_q <= 1'b1;
        IEN_CLR: ien_q <= 1'b0;
        default: ien_q <= ien_q;
      endcase
      if (mask_we_i) mask_q <= mask_i;
      pend_q <= (pend_q | add) & ~(take_now ? win_oh : '0);
    end
  end

  vic_vec_gen #(
    .NCH(NCH), .IDX_W(IDX_W), .AW(AW), .PC_W(PC_W), .VEC_BASE(VEC_BASE)
  ) u_vec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take_now),
    .idx_i  (win_idx),
    .pc_i   (pc_i),
    .take_o (take_o),
    .chan_o (chan_o),
    .vec_o  (vec_addr_o),
    .pc_o   (saved_pc_o)
  );

  assign pc_save_addr_o = PC_SAVE_ADDR;

  a_r2_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !ien_q) |=> !take_o);
  a_r4_take_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !ien_q);
  a_r10_winner_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !pend_q[chan_o]);
  a_r13_off_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_off_i |=> !ien_q);
  a_r3_single_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_oh));
  a_r6_vec_in_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vec_addr_o >= VEC_BASE && vec_addr_o < VEC_BASE + AW'(NCH)));
endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dev_wake = '0, sw_post = '0, mask_d = '0, pc = '0;
  logic        sw_we = 1'b0, mask_we = 1'b0, on = 1'b0, off = 1'b0, bnd = 1'b0;
  logic        take;
  logic [3:0]  chan;
  logic [15:0] pcsa, vec, spc;

  int n_chk = 0, n_fail = 0;

  // bench model
  logic        m_ien;
  logic [15:0] m_mask, m_pend, m_hold, m_stage;
  logic        e_take;
  logic [3:0]  e_chan;
  logic [15:0] e_vec, e_pc;

  always #4 clk = ~clk;

  vec_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .dev_wake_i(dev_wake), .sw_post_we_i(sw_we),
    .sw_post_i(sw_post), .mask_we_i(mask_we), .mask_i(mask_d), .int_on_i(on),
    .int_off_i(off), .boundary_i(bnd), .pc_i(pc), .take_o(take), .chan_o(chan),
    .pc_save_addr_o(pcsa), .vec_addr_o(vec), .saved_pc_o(spc)
  );

  function automatic int top_chan(input logic [15:0] v);
    int r = 0;
    for (int i = 1; i < 16; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [15:0] add, elig;
    int w;
    logic tk, mg;
    mg   = on & ~off;
    elig = m_pend & m_mask & 16'hFFFE;
    w    = top_chan(elig);
    tk   = bnd & m_ien & (w != 0);
    add  = ((m_ien | mg) ? dev_wake : 16'h0) | (mg ? (m_hold | m_stage) : 16'h0);
    if (mg) m_hold = 16'h0; else if (!m_ien) m_hold = m_hold | dev_wake;
    if (mg) m_stage = sw_we ? sw_post : 16'h0; else if (sw_we) m_stage = m_stage | sw_post;
    m_pend = (m_pend | add) & ~(tk ? (16'h1 << w) : 16'h0);
    if (mask_we) m_mask = mask_d;
    if (tk || off) m_ien = 1'b0; else if (on) m_ien = 1'b1;
    e_take = tk;
    if (tk) begin
      e_chan = 4'(w);
      e_vec  = 16'o501 + 16'(15 - w);
      e_pc   = pc;
    end
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    #2;
    chk("R2 take", {31'b0, take}, {31'b0, e_take});
    chk("R3 chan", {28'b0, chan}, {28'b0, e_chan});
    chk("R6 vec", {16'b0, vec}, {16'b0, e_vec});
    chk("R5 pc", {16'b0, spc}, {16'b0, e_pc});
    chk("R5 save addr", {16'b0, pcsa}, 32'o500);
    dev_wake = '0; sw_we = 0; sw_post = '0; mask_we = 0; on = 0; off = 0; bnd = 0;
    pc = 16'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_ien = 0; m_mask = 0; m_pend = 0; m_hold = 0; m_stage = 0;
    e_take = 0; e_chan = 0; e_vec = 0; e_pc = 0;
    #13 rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 reset take", {31'b0, take}, 32'd0);
    chk("R1 reset pc", {16'b0, spc}, 32'd0);
    // R1: empty boundary, then enable + boundary
    bnd = 1; cyc();
    on = 1; cyc();
    bnd = 1; cyc(); chk("R1 empty after enable", {31'b0, take}, 32'd0);
    // R12: bit 0 only
    mask_we = 1; mask_d = 16'hFFFF; dev_wake = 16'h0001; cyc();
    sw_we = 1; sw_post = 16'h0001; cyc();
    on = 1; cyc();
    bnd = 1; cyc(); chk("R12 bit0 ignored", {31'b0, take}, 32'd0);
    off = 1; cyc();
    // R8: held while off
    dev_wake = 16'h0020; cyc();
    bnd = 1; cyc(); chk("R8 no take while off", {31'b0, take}, 32'd0);
    on = 1; cyc();
    bnd = 1; cyc(); chk("R8 held wake taken", {27'b0, take, chan}, {27'b0, 1'b1, 4'd5});
    // R4: disabled after take
    dev_wake = 16'h0080; cyc();
    bnd = 1; cyc(); chk("R4 off after take", {31'b0, take}, 32'd0);
    on = 1; cyc();
    bnd = 1; cyc(); chk("R4 resumes after enable", {28'b0, chan}, 32'd7);
    // R9: software post waits for enable
    on = 1; cyc();
    sw_we = 1; sw_post = 16'h0200; cyc();
    bnd = 1; cyc(); chk("R9 post not yet", {31'b0, take}, 32'd0);
    on = 1; sw_we = 1; sw_post = 16'h0400; cyc();
    bnd = 1; cyc(); chk("R9 post after enable", {28'b0, chan}, 32'd9);
    on = 1; cyc();
    bnd = 1; cyc(); chk("R9 same-cycle post deferred", {28'b0, chan}, 32'd10);
    // R3 / R10: several at once
    on = 1; cyc();
    dev_wake = 16'h5008; cyc();
    bnd = 1; cyc(); chk("R3 highest first", {28'b0, chan}, 32'd14);
    on = 1; cyc();
    bnd = 1; cyc(); chk("R10 others kept", {28'b0, chan}, 32'd12);
    on = 1; cyc();
    bnd = 1; cyc(); chk("R10 last kept", {28'b0, chan}, 32'd3);
    // R7: direct wake seen one cycle later
    on = 1; cyc();
    dev_wake = 16'h0004; cyc();
    bnd = 1; cyc(); chk("R7 direct wake", {27'b0, take, chan}, {27'b0, 1'b1, 4'd2});
    // R11: device and software in same cycle
    on = 1; cyc();
    dev_wake = 16'h0010; sw_we = 1; sw_post = 16'h0040; cyc();
    bnd = 1; cyc(); chk("R11 device kept", {28'b0, chan}, 32'd4);
    on = 1; cyc();
    bnd = 1; cyc(); chk("R11 software kept", {28'b0, chan}, 32'd6);
    // R13: off strobe
    on = 1; cyc();
    dev_wake = 16'h0100; off = 1; cyc();
    bnd = 1; cyc(); chk("R13 off", {31'b0, take}, 32'd0);
    on = 1; off = 1; cyc();
    bnd = 1; cyc(); chk("R13 off beats on", {31'b0, take}, 32'd0);
    on = 1; cyc();
    bnd = 1; cyc(); chk("R13 then taken", {28'b0, chan}, 32'd8);
    // R14: mask gating
    mask_we = 1; mask_d = ~16'h0400; on = 1; cyc();
    dev_wake = 16'h0400; cyc();
    bnd = 1; cyc(); chk("R14 masked", {31'b0, take}, 32'd0);
    mask_we = 1; mask_d = 16'hFFFF; cyc();
    bnd = 1; cyc(); chk("R14 unmasked", {28'b0, chan}, 32'd10);
    // R6: table ends
    on = 1; cyc();
    dev_wake = 16'h8002; cyc();
    bnd = 1; cyc(); chk("R6 chan15 vec", {16'b0, vec}, 32'o501);
    on = 1; cyc();
    bnd = 1; cyc(); chk("R6 chan1 vec", {16'b0, vec}, 32'o517);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(3) == 0) dev_wake = 16'(1) << $urandom_range(15);
      if ($urandom_range(7) == 0) begin sw_we = 1; sw_post = 16'($urandom); end
      if ($urandom_range(31) == 0) begin mask_we = 1; mask_d = 16'($urandom) | 16'hF000; end
      on  = ($urandom_range(5) == 0);
      off = ($urandom_range(19) == 0);
      bnd = ($urandom_range(2) == 0);
      cyc();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule